// File: doc/BRIEF.md
# Sparse Indexed Register Bank

This block is a register bank that covers a logical address space of `LOGICAL_SIZE` entries but holds storage only at a fixed, sorted list of populated indices given by the `SLOT_IDX` parameter array. Each populated slot has its own write port, selected by its position in that list. Slot 0 of the ports is the lowest populated index. The bank therefore needs only `NUM_SLOTS` registers instead of `LOGICAL_SIZE`.

A single combinational read port takes a logical address and returns one of three things. If the address is a populated index, it returns that slot's contents. If the address is a hole at or below the largest populated index, it returns a fixed hole value. If the address is above the largest populated index, it returns an out-of-bounds result. That result is the slot at logical index 0 when that index is populated, and zero otherwise. With the default hole value of zero, the port reads exactly like a dense vector whose unused entries hold zero.

The read multiplexer can be built in three ways, chosen by a parameter: a binary slot number, a one-hot select, or a priority chain of compares. All three give the same result. The read port cannot change any state. An index list that is not strictly increasing, or that falls outside the logical size, stops elaboration.

Top module: `sparse_reg_bank`

## Requirements
- R1: When the read address equals a populated index, `rdData` returns that slot's stored value. A write through `wrEn[k]`/`wrData[k]` is captured on the rising clock edge and shows on `rdData` from that edge onward. In the cycle before the edge, `rdData` still shows the old value.
- R2: While `rst` is high at a rising edge, every slot is cleared to zero, and reset takes priority over any write enable in that cycle.
- R3: A read address that is not populated and is not above the largest populated index returns `HOLE_VAL`. `HOLE_VAL` defaults to zero.
- R4: A read address above the largest populated index returns the out-of-bounds result. This includes every address from `LOGICAL_SIZE` up to `2**ADDR_W - 1`. The result is the contents of the slot at logical index 0 when `SLOT_IDX[0] == 0`, and zero otherwise.
- R5: `MUX_STYLE` selects the read multiplexer, with the encoding 0 = binary slot number, 1 = one-hot select and 2 = priority chain. For every address and stored state, all three styles return the same `rdData`.
- R6: Changing `rdAddr` over any sequence of addresses, with no write enable asserted, leaves every stored slot value unchanged.
- R7: The slot write ports are independent. Any set of `wrEn` bits may be high in one cycle, and each enabled slot takes its own data. Slots whose enable is low keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all slot updates occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all slots |
| wrEn | input | NUM_SLOTS | Per-slot write enable; bit k addresses the k-th entry of the index list |
| wrData | input | NUM_SLOTS x DATA_W | Per-slot write data; element k goes to the k-th slot |
| rdAddr | input | ADDR_W | Logical read address; wide enough to reach past the logical size |
| rdData | output | DATA_W | Combinational read result: slot value, hole value or out-of-bounds result |

## Verification
The two functions that can meet in one cycle are a slot write and a combinational read of that same slot. The case that matters most is a write to slot 0 while the read address is out of bounds, because the out-of-bounds path also shows slot 0. The bench provokes both cases on purpose by holding the read address on the slot being written. It also reaches them at random, by drawing write masks and read addresses together. Before the edge, the read must show the model's old value; after the edge, it must show the new one. A reset edge with every write enable high must leave all slots at zero.

// File: rtl/sparse_bank_pkg.sv
package sparse_bank_pkg;

  // Read multiplexer construction
  typedef enum logic [1:0] {
    MUX_BINARY = 2'd0,
    MUX_ONEHOT = 2'd1,
    MUX_CHAIN  = 2'd2
  } muxStyle_e;

  // Classification strobes from the address decoder to the datapath
  typedef struct packed {
    logic hit;   // address is a populated index
    logic hole;  // unpopulated, not above the largest populated index
    logic oob;   // above the largest populated index
  } rdSel_t;

endpackage

// File: rtl/sparse_bank_ctrl.sv
module sparse_bank_ctrl
  import sparse_bank_pkg::*;
#(
  parameter int          NUM_SLOTS = 5,
  parameter int          ADDR_W    = 5,
  parameter int          SEL_W     = 3,
  parameter int unsigned SLOT_IDX [NUM_SLOTS] = '{default: 0}
) (
  input  logic [ADDR_W-1:0]    rdAddr,
  output rdSel_t               rdSel,
  output logic [NUM_SLOTS-1:0] hitOh,
  output logic [SEL_W-1:0]     hitBin
);

  localparam int LAST = NUM_SLOTS - 1;

  logic [NUM_SLOTS-1:0] eqVec;
  logic [NUM_SLOTS-1:0] aboveVec;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_cmp
    assign eqVec[gi]    = (rdAddr == ADDR_W'(SLOT_IDX[gi]));
    assign aboveVec[gi] = (rdAddr >  ADDR_W'(SLOT_IDX[gi]));
  end

  // Sorted list: the number of populated indices below the address is the
  // dense slot number on a hit.
  assign hitBin     = SEL_W'($countones(aboveVec));
  assign hitOh      = eqVec;
  assign rdSel.hit  = |eqVec;
  assign rdSel.oob  = aboveVec[LAST];
  assign rdSel.hole = ~(|eqVec) & ~aboveVec[LAST];

endmodule

// File: rtl/sparse_bank_dp.sv
module sparse_bank_dp
  import sparse_bank_pkg::*;
#(
  parameter int          NUM_SLOTS = 5,
  parameter int          DATA_W    = 16,
  parameter int          ADDR_W    = 5,
  parameter int          SEL_W     = 3,
  parameter int unsigned SLOT_IDX [NUM_SLOTS] = '{default: 0},
  parameter muxStyle_e   MUX_STYLE = MUX_BINARY,
  parameter logic [DATA_W-1:0] HOLE_VAL = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SLOTS-1:0]              wrEn,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]                 rdAddr,
  input  rdSel_t                            rdSel,
  input  logic [NUM_SLOTS-1:0]              hitOh,
  input  logic [SEL_W-1:0]                  hitBin,
  output logic [DATA_W-1:0]                 rdData
);

  localparam bit ZERO_POP = (SLOT_IDX[0] == 0);

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slotQ;
  logic [DATA_W-1:0]                oobVal;
  logic [DATA_W-1:0]                missVal;
  logic                             unusedSink;

  // Dense storage: one register per populated index
  always_ff @(posedge clk) begin
    if (rst) begin
      slotQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (wrEn[i]) slotQ[i] <= wrData[i];
      end
    end
  end

  if (ZERO_POP) begin : g_oobFirst
    assign oobVal = slotQ[0];
  end else begin : g_oobZero
    assign oobVal = '0;
  end

  assign missVal    = rdSel.oob ? oobVal : HOLE_VAL;
  assign unusedSink = ^{hitOh, hitBin, rdAddr};

  if (MUX_STYLE == MUX_BINARY) begin : g_binary
    logic [DATA_W-1:0] picked;
    always_comb begin
      picked = '0;
      if (int'(hitBin) < NUM_SLOTS) picked = slotQ[hitBin];
    end
    assign rdData = rdSel.hit ? picked : missVal;
  end else if (MUX_STYLE == MUX_ONEHOT) begin : g_onehot
    logic [DATA_W-1:0] picked;
    always_comb begin
      picked = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (hitOh[i]) picked = picked | slotQ[i];
      end
    end
    assign rdData = rdSel.hit ? picked : missVal;
  end else begin : g_chain
    // Priority chain of direct compares; lowest list position wins last
    always_comb begin
      rdData = missVal;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
        if (rdAddr == ADDR_W'(SLOT_IDX[i])) rdData = slotQ[i];
      end
    end
  end

endmodule

// File: rtl/sparse_reg_bank.sv
module sparse_reg_bank
  import sparse_bank_pkg::*;
#(
  parameter int          LOGICAL_SIZE = 16,
  parameter int          NUM_SLOTS    = 5,
  parameter int          DATA_W       = 16,
  parameter int          ADDR_W       = $clog2(LOGICAL_SIZE) + 1,
  parameter int unsigned SLOT_IDX [NUM_SLOTS] = '{0, 3, 4, 9, 12},
  parameter muxStyle_e   MUX_STYLE    = MUX_BINARY,
  parameter logic [DATA_W-1:0] HOLE_VAL = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SLOTS-1:0]              wrEn,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic [DATA_W-1:0]                 rdData
);

  localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS + 1) : 1;

  function automatic bit listOk();
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (SLOT_IDX[i] >= LOGICAL_SIZE) return 1'b0;
      if (i > 0 && SLOT_IDX[i] <= SLOT_IDX[i-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  localparam bit LIST_OK = listOk();
  localparam bit ADDR_OK = (ADDR_W >= $clog2(LOGICAL_SIZE + 1));

  if (!LIST_OK) begin : g_badList
    $error("sparse_reg_bank: SLOT_IDX must be strictly increasing and below LOGICAL_SIZE");
  end
  if (!ADDR_OK) begin : g_badAddr
    $error("sparse_reg_bank: ADDR_W must reach past LOGICAL_SIZE - 1");
  end

  rdSel_t               rdSel;
  logic [NUM_SLOTS-1:0] hitOh;
  logic [SEL_W-1:0]     hitBin;

  sparse_bank_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .SLOT_IDX  (SLOT_IDX)
  ) i_ctrl (
    .rdAddr (rdAddr),
    .rdSel  (rdSel),
    .hitOh  (hitOh),
    .hitBin (hitBin)
  );

  sparse_bank_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .SLOT_IDX  (SLOT_IDX),
    .MUX_STYLE (MUX_STYLE),
    .HOLE_VAL  (HOLE_VAL)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdSel  (rdSel),
    .hitOh  (hitOh),
    .hitBin (hitBin),
    .rdData (rdData)
  );

endmodule

// File: rtl/sparse_reg_bank_chk.sv
module sparse_reg_bank_chk
  import sparse_bank_pkg::*;
#(
  parameter int          NUM_SLOTS = 5,
  parameter int          DATA_W    = 16,
  parameter int          ADDR_W    = 5,
  parameter int unsigned SLOT_IDX [NUM_SLOTS] = '{default: 0},
  parameter logic [DATA_W-1:0] HOLE_VAL = '0
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_SLOTS-1:0]              wrEn,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0]  wrData,
  input logic [ADDR_W-1:0]                 rdAddr,
  input logic [DATA_W-1:0]                 rdData,
  input rdSel_t                            rdSel
);

  localparam bit ZERO_POP = (SLOT_IDX[0] == 0);

  // Shadow of the first slot, used for the out-of-bounds check
  logic [DATA_W-1:0] shadowFirst;
  always_ff @(posedge clk) begin
    if (rst)          shadowFirst <= '0;
    else if (wrEn[0]) shadowFirst <= wrData[0];
  end

  p_class_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot({rdSel.hit, rdSel.hole, rdSel.oob}));

  p_hole_value_r3: assert property (@(posedge clk) disable iff (rst)
    rdSel.hole |-> rdData == HOLE_VAL);

  p_oob_value_r4: assert property (@(posedge clk) disable iff (rst)
    rdSel.oob |-> rdData == (ZERO_POP ? shadowFirst : '0));

  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rdSel.hit) |-> rdData == '0);

  for (genvar gj = 0; gj < NUM_SLOTS; gj++) begin : g_wr
    p_write_visible_r1: assert property (@(posedge clk) disable iff (rst)
      (wrEn[gj] ##1 (rdAddr == ADDR_W'(SLOT_IDX[gj]))) |-> rdData == $past(wrData[gj]));
  end

endmodule

bind sparse_reg_bank sparse_reg_bank_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SLOT_IDX  (SLOT_IDX),
  .HOLE_VAL  (HOLE_VAL)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .rdSel  (rdSel)
);

// File: tb/test_sparse_reg_bank.sv
`timescale 1ns/1ps
module test_sparse_reg_bank;
  import sparse_bank_pkg::*;

  localparam int LSIZE = 16;
  localparam int NS    = 5;
  localparam int DW    = 16;
  localparam int AW    = $clog2(LSIZE) + 1;

  typedef int unsigned idxList_t [NS];
  localparam idxList_t LIST_A = '{0, 3, 4, 9, 12};
  localparam idxList_t LIST_B = '{2, 5, 6, 10, 13};
  localparam logic [DW-1:0] HOLE_B = 16'hDEAD;

  logic clk = 1'b0;
  logic rst;
  logic [NS-1:0]         wrEn;
  logic [NS-1:0][DW-1:0] wrData;
  logic [AW-1:0]         rdAddr;
  logic [DW-1:0]         rdA, rdO, rdC, rdB;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [DW-1:0] m [NS];

  always #4 clk = ~clk;

  sparse_reg_bank #(.LOGICAL_SIZE(LSIZE), .NUM_SLOTS(NS), .DATA_W(DW),
    .SLOT_IDX(LIST_A), .MUX_STYLE(MUX_BINARY)) i_sparse_reg_bank (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdA));

  sparse_reg_bank #(.LOGICAL_SIZE(LSIZE), .NUM_SLOTS(NS), .DATA_W(DW),
    .SLOT_IDX(LIST_A), .MUX_STYLE(MUX_ONEHOT)) i_sparse_reg_bank_oh (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdO));

  sparse_reg_bank #(.LOGICAL_SIZE(LSIZE), .NUM_SLOTS(NS), .DATA_W(DW),
    .SLOT_IDX(LIST_A), .MUX_STYLE(MUX_CHAIN)) i_sparse_reg_bank_ch (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdC));

  sparse_reg_bank #(.LOGICAL_SIZE(LSIZE), .NUM_SLOTS(NS), .DATA_W(DW),
    .SLOT_IDX(LIST_B), .MUX_STYLE(MUX_CHAIN), .HOLE_VAL(HOLE_B)) i_sparse_reg_bank_b (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdB));

  // Expected read of a dense reference built from the requirements
  function automatic logic [DW-1:0] expOf(input idxList_t lst, input int a,
                                          input logic [DW-1:0] holeV);
    if (a > int'(lst[NS-1])) return (lst[0] == 0) ? m[0] : '0;   // R4
    for (int i = 0; i < NS; i++) if (a == int'(lst[i])) return m[i]; // R1
    return holeV;                                                 // R3
  endfunction

  function automatic string classOf(input idxList_t lst, input int a);
    if (a > int'(lst[NS-1])) return "R4";
    for (int i = 0; i < NS; i++) if (a == int'(lst[i])) return "R1";
    return "R3";
  endfunction

  task automatic cmp(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string tag, input int a);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, act, exp);
    end
  endtask

  // Compare all four instances at the current address
  task automatic checkNow(input string forceTag);
    int a = int'(rdAddr);
    string ta = (forceTag != "") ? forceTag : classOf(LIST_A, a);
    string tb = (forceTag != "") ? forceTag : classOf(LIST_B, a);
    cmp(rdA, expOf(LIST_A, a, '0), ta, a);
    cmp(rdO, expOf(LIST_A, a, '0), {"R5/", ta}, a);
    cmp(rdC, expOf(LIST_A, a, '0), {"R5/", ta}, a);
    cmp(rdB, expOf(LIST_B, a, HOLE_B), tb, a);
  endtask

  task automatic sweep(input string forceTag);
    for (int a = 0; a <= LSIZE + 2; a++) begin
      rdAddr = AW'(a);
      #1;
      checkNow(forceTag);
    end
  endtask

  // One clock edge; model follows the requirements
  task automatic tick();
    @(posedge clk);
    #1;
    if (rst) begin
      for (int i = 0; i < NS; i++) m[i] = '0;                    // R2
    end else begin
      for (int i = 0; i < NS; i++) if (wrEn[i]) m[i] = wrData[i]; // R7
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedV;
    seedV  = $urandom(32'h5A17C0DE);
    rst    = 1'b1;
    wrEn   = '0;
    wrData = '0;
    rdAddr = '0;
    for (int i = 0; i < NS; i++) m[i] = 'x;
    tick(); tick(); tick();
    @(negedge clk);
    rst = 1'b0;

    // R2: every slot zero after reset
    sweep("R2");

    // R7: all slots written in one cycle with distinct data
    @(negedge clk);
    wrEn = '1;
    for (int i = 0; i < NS; i++) wrData[i] = DW'(16'h1100 + i * 16'h0101);
    tick();
    @(negedge clk);
    wrEn = '0;
    sweep("R7");

    // R7: one slot written, the others keep their values
    @(negedge clk);
    wrEn = 5'b01000;
    wrData = '0;
    wrData[3] = 16'hBEEF;
    tick();
    @(negedge clk);
    wrEn = '0;
    sweep("R7");

    // R1: write and read of the same slot in one cycle
    @(negedge clk);
    rdAddr = AW'(4);
    wrEn = 5'b00100;
    wrData[2] = 16'h1234;
    #1;
    cmp(rdA, m[2], "R1 before edge", 4);
    tick();
    cmp(rdA, 16'h1234, "R1 after edge", 4);
    cmp(rdC, 16'h1234, "R5 after edge", 4);

    // R4: out-of-bounds read while slot 0 is written
    @(negedge clk);
    rdAddr = AW'(LSIZE + 1);
    wrEn = 5'b00001;
    wrData[0] = 16'h0F0F;
    #1;
    cmp(rdA, m[0], "R4 before edge", LSIZE + 1);
    tick();
    cmp(rdA, 16'h0F0F, "R4 after edge", LSIZE + 1);
    cmp(rdO, 16'h0F0F, "R5 oob", LSIZE + 1);
    cmp(rdB, 16'h0000, "R4 no index 0", LSIZE + 1);
    @(negedge clk);
    wrEn = '0;
    rdAddr = '1;
    #1;
    checkNow("R4");

    // Random writes and reads
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      wrEn = NS'($urandom);
      for (int i = 0; i < NS; i++) wrData[i] = DW'($urandom);
      rdAddr = AW'($urandom_range(0, LSIZE + 2));
      #1;
      checkNow("");
      tick();
      checkNow("");
    end

    // R6: reads alone never change storage
    @(negedge clk);
    wrEn = '0;
    for (int it = 0; it < 40; it++) begin
      rdAddr = AW'($urandom);
      tick();
      @(negedge clk);
    end
    sweep("R6");

    // R2: reset wins over write enables on the same edge
    @(negedge clk);
    rst = 1'b1;
    wrEn = '1;
    for (int i = 0; i < NS; i++) wrData[i] = DW'($urandom);
    tick();
    @(negedge clk);
    rst = 1'b0;
    wrEn = '0;
    sweep("R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule